// File: doc/BRIEF.md
# Prescaled Hold PWM Generator

This block produces the single pulse-width-modulated pin that holds a solenoid once its attack pulse is over. A power-of-two prescaler derived from the system clock sets the base tick. An 8-bit counter advances once per tick, runs from zero up to a programmable top value and then wraps. The pin is high while the counter is below the duty threshold. A duty value of 255 is a special case that keeps the pin high for the whole period.

Software presents a duty value, a top value and a 4-bit divider code, then pulses the load strobe. Code k divides the clock by 2^(k-1), so codes 1 to 15 give division by 1 up to 16384. Code 0 is not a valid setting. A load that carries it is discarded as a whole, and an error output is raised. A valid load is held in a staging copy. It moves into the running copy only when the counter wraps, or at once when the generator is disabled, so a period never mixes two settings.

Top module: `hold_pwm_gen`

## Requirements
- R1: With divider code k (1..15), the counter advances exactly once every 2^(k-1) clock cycles while enabled.
- R2: The counter counts 0, 1, ..., top and then returns to 0. One PWM period therefore lasts (top+1)*2^(k-1) clock cycles, and top = 0 is allowed.
- R3: While enabled, pwm_out is high exactly while the counter is below duty. Every period therefore begins with min(duty, top+1)*2^(k-1) high cycles followed by the low remainder, and duty 0 gives a constant low.
- R4: A running duty of 255 keeps pwm_out high on every enabled cycle, whatever the top value.
- R5: After reset the running setting is duty 127, top 255 and code 5. cfg_err is 0, and pwm_out is 0 while en is 0.
- R6: A load with div_code_in = 0 changes none of the three settings, and cfg_err is 1 from the clock edge after that load onward. A later load with a non-zero code returns cfg_err to 0 at the edge after it.
- R7: When enabled, a valid load takes effect at the first counter wrap after the load. The period in progress finishes with the old values. When disabled, a valid load takes effect at the second clock edge after the load strobe is sampled.
- R8: While en is 0, pwm_out is 0 in that same cycle, and the counter and prescaler are held at zero. When en returns to 1, a fresh period starts from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; low forces the pin low and clears the counters |
| load | input | 1 | One-cycle strobe that captures duty_in, top_in and div_code_in |
| duty_in | input | 8 | Duty threshold (255 = always high) |
| top_in | input | 8 | Counter wrap value |
| div_code_in | input | 4 | Prescale code k, division by 2^(k-1); 0 is rejected |
| pwm_out | output | 1 | Hold PWM pin |
| cfg_err | output | 1 | Set by a rejected load, cleared by the next valid load |

## Verification
pwm_out is a combinational function of the enable and the registered counter. It therefore changes in the cycle right after the edge that steps the counter, and it falls in the same cycle that en drops. A load is captured at one edge and, when the generator is idle, reaches the running setting at the next edge. When the generator is running, the setting changes at the wrap edge, and the output reflects it from the following cycle. cfg_err follows one edge after the load. The bench drives inputs on the falling edge and samples 1 ns later. Sample j after enable therefore reflects j rising edges, and every waveform is compared sample by sample against (j mod period) < high-count. Expected high counts and periods are worked out from R1 to R4 by hand.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;

  localparam int CNT_W  = 8;
  localparam int CODE_W = 4;
  // widest prescale is 2^(2^CODE_W - 2) cycles, so the counter needs that many bits
  localparam int PRE_W  = (1 << CODE_W) - 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [PRE_W-1:0]  pre_t;

  typedef struct packed {
    cnt_t  duty;
    cnt_t  top;
    code_t code;
  } hpwm_cfg_t;

  localparam hpwm_cfg_t CFG_RESET = '{duty: 8'd127, top: 8'd255, code: 4'd5};

  // terminal value of the prescale counter: 2^(code-1) - 1
  function automatic pre_t prescale_limit(input code_t code);
    logic [PRE_W:0] one_hot;
    logic [PRE_W:0] lim;
    if (code == '0) begin
      return '0;
    end
    one_hot = (PRE_W+1)'(1) << (code - code_t'(1));
    lim     = one_hot - (PRE_W+1)'(1);
    return lim[PRE_W-1:0];
  endfunction

  function automatic logic code_valid(input code_t code);
    return code != '0;
  endfunction

  // pin level for a given count; the all-ones duty means always high
  function automatic logic pwm_level(input cnt_t cnt, input cnt_t duty);
    return (duty == '1) || (cnt < duty);
  endfunction

endpackage

// File: rtl/hpwm_prescaler.sv
module hpwm_prescaler
  import hpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  code_t code,
  output logic  tick,
  output pre_t  pre_cnt,
  output pre_t  limit
);

  pre_t pre_q;

  assign limit   = prescale_limit(code);
  assign tick    = en && (pre_q == limit);
  assign pre_cnt = pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!en || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + pre_t'(1);
    end
  end

endmodule

// File: rtl/hpwm_cfg_stage.sv
module hpwm_cfg_stage
  import hpwm_pkg::*;
#(
  parameter hpwm_cfg_t RESET_CFG = CFG_RESET
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      load,
  input  hpwm_cfg_t cfg_in,
  input  logic      wrap,
  output hpwm_cfg_t act_cfg,
  output logic      apply,
  output logic      cfg_err
);

  hpwm_cfg_t staged_q;
  hpwm_cfg_t act_q;
  logic      pending_q;
  logic      err_q;
  logic      load_ok;
  logic      load_bad;

  assign load_ok  = load && code_valid(cfg_in.code);
  assign load_bad = load && !code_valid(cfg_in.code);
  // hand over at a period boundary, or at once when the counter is idle
  assign apply    = pending_q && (wrap || !en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= RESET_CFG;
    end else if (load_ok) begin
      staged_q <= cfg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (load_ok) begin
      pending_q <= 1'b1;
    end else if (apply) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= RESET_CFG;
    end else if (apply) begin
      act_q <= staged_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (load_bad) begin
      err_q <= 1'b1;
    end else if (load_ok) begin
      err_q <= 1'b0;
    end
  end

  assign act_cfg = act_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/hpwm_count_cmp.sv
module hpwm_count_cmp
  import hpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  cnt_t top,
  input  cnt_t duty,
  output cnt_t cnt,
  output logic wrap,
  output logic pwm_out
);

  cnt_t cnt_q;
  logic at_top;

  assign at_top  = (cnt_q >= top);
  assign wrap    = tick && at_top;
  assign cnt     = cnt_q;
  assign pwm_out = en && pwm_level(cnt_q, duty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_top ? '0 : cnt_q + cnt_t'(1);
    end
  end

endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen
  import hpwm_pkg::*;
#(
  parameter int unsigned DUTY_RST = 127,
  parameter int unsigned TOP_RST  = 255,
  parameter int unsigned CODE_RST = 5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       load,
  input  logic [7:0] duty_in,
  input  logic [7:0] top_in,
  input  logic [3:0] div_code_in,
  output logic       pwm_out,
  output logic       cfg_err
);

  localparam hpwm_cfg_t RST_CFG = '{duty: cnt_t'(DUTY_RST),
                                    top:  cnt_t'(TOP_RST),
                                    code: code_t'(CODE_RST)};

  hpwm_cfg_t cfg_in;
  hpwm_cfg_t act_cfg;
  logic      apply;
  logic      tick;
  logic      wrap;
  pre_t      pre_cnt;
  pre_t      pre_lim;
  cnt_t      cnt;

  assign cfg_in = '{duty: duty_in, top: top_in, code: div_code_in};

  hpwm_cfg_stage #(.RESET_CFG(RST_CFG)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .cfg_in  (cfg_in),
    .wrap    (wrap),
    .act_cfg (act_cfg),
    .apply   (apply),
    .cfg_err (cfg_err)
  );

  hpwm_prescaler pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .code    (act_cfg.code),
    .tick    (tick),
    .pre_cnt (pre_cnt),
    .limit   (pre_lim)
  );

  hpwm_count_cmp cmp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .top     (act_cfg.top),
    .duty    (act_cfg.duty),
    .cnt     (cnt),
    .wrap    (wrap),
    .pwm_out (pwm_out)
  );

endmodule

// File: rtl/hold_pwm_gen_chk.sv
module hold_pwm_gen_chk
  import hpwm_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  en,
  input logic  load,
  input code_t div_code_in,
  input logic  pwm_out,
  input logic  cfg_err,
  input logic  tick,
  input logic  wrap,
  input logic  apply,
  input cnt_t  cnt,
  input cnt_t  act_top,
  input cnt_t  act_duty,
  input pre_t  pre_cnt,
  input pre_t  pre_lim
);

  assert_pre_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> (pre_cnt == $past(pre_cnt) + pre_t'(1)));

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pre_cnt <= pre_lim));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= act_top));

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_duty == 8'hFF) |-> pwm_out);

  assert_bad_code_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && div_code_in == '0) |=> cfg_err);

  assert_mid_period_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(act_duty) && $stable(act_top)));

  assert_apply_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && en) |-> wrap);

  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  assert_off_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (cnt == '0 && pre_cnt == '0));

endmodule

bind hold_pwm_gen hold_pwm_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .load        (load),
  .div_code_in (div_code_in),
  .pwm_out     (pwm_out),
  .cfg_err     (cfg_err),
  .tick        (tick),
  .wrap        (wrap),
  .apply       (apply),
  .cnt         (cnt),
  .act_top     (act_cfg.top),
  .act_duty    (act_cfg.duty),
  .pre_cnt     (pre_cnt),
  .pre_lim     (pre_lim)
);

// File: tb/hold_pwm_gen_tb_top.sv
module hold_pwm_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [7:0] duty_in = '0;
  logic [7:0] top_in = '0;
  logic [3:0] div_code_in = '0;
  logic       pwm_out;
  logic       cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hold_pwm_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .load        (load),
    .duty_in     (duty_in),
    .top_in      (top_in),
    .div_code_in (div_code_in),
    .pwm_out     (pwm_out),
    .cfg_err     (cfg_err)
  );

  // {duty, top, code, high cycles per period, period}
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {8'd127, 8'd255, 4'd5,  16'd2032,  16'd4096},
    {8'd0,   8'd255, 4'd1,  16'd0,     16'd256},
    {8'd255, 8'd255, 4'd1,  16'd256,   16'd256},
    {8'd254, 8'd255, 4'd1,  16'd254,   16'd256},
    {8'd10,  8'd20,  4'd3,  16'd40,    16'd84},
    {8'd50,  8'd20,  4'd2,  16'd42,    16'd42},
    {8'd1,   8'd1,   4'd15, 16'd16384, 16'd32768},
    {8'd3,   8'd0,   4'd4,  16'd8,     16'd8},
    {8'd0,   8'd0,   4'd1,  16'd0,     16'd1}
  };
  localparam string VTAG [NV] = '{
    "R1/R3 prescale 16", "R3 duty zero", "R4 full duty top 255",
    "R3 duty 254", "R2/R3 top 20 div 4", "R3 duty above top",
    "R1 division 16384", "R2 top zero", "R2/R3 top zero duty zero"
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // load while idle; active two edges later
  task automatic load_idle(input int d, input int t, input int c);
    @(negedge clk);
    duty_in = 8'(d); top_in = 8'(t); div_code_in = 4'(c); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // enable at a falling edge and compare every sample with the expected waveform
  task automatic shape(input int hi, input int per, input int nper, output int errs);
    errs = 0;
    en = 1'b1;
    for (int j = 0; j < per * nper; j++) begin
      #1;
      if (pwm_out !== ((j % per) < hi)) errs++;
      @(negedge clk);
    end
    en = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int errs;
    int fresh_errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(pwm_out == 1'b0, "R5 idle output low", int'(pwm_out), 0);
    chk(cfg_err == 1'b0, "R5 error clear after reset", int'(cfg_err), 0);
    @(negedge clk);

    // R5: defaults 127/255/code 5, no load
    shape(2032, 4096, 1, errs);
    chk(errs == 0, "R5 default waveform mismatches", errs, 0);

    for (int v = 0; v < NV; v++) begin
      load_idle(int'(VEC[v][51:44]), int'(VEC[v][43:36]), int'(VEC[v][35:32]));
      shape(int'(VEC[v][31:16]), int'(VEC[v][15:0]), 2, errs);
      chk(errs == 0, VTAG[v], errs, 0);
    end

    // R6: a code-0 load is rejected and flagged
    load_idle(10, 20, 3);
    @(negedge clk);
    duty_in = 8'd200; top_in = 8'd5; div_code_in = 4'd0; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    #1;
    chk(cfg_err == 1'b1, "R6 error raised", int'(cfg_err), 1);
    @(negedge clk);
    @(negedge clk);
    shape(40, 84, 2, errs);
    chk(errs == 0, "R6 setting kept after bad code", errs, 0);
    load_idle(10, 20, 3);
    #1;
    chk(cfg_err == 1'b0, "R6 error cleared by valid load", int'(cfg_err), 0);

    // R7: a load in mid period applies at the wrap
    @(negedge clk);
    errs = 0;
    en = 1'b1;
    for (int j = 0; j < 168; j++) begin
      #1;
      if (pwm_out !== ((j < 84) ? (j < 40) : 1'b0)) errs++;
      if (j == 30) begin
        duty_in = 8'd0; top_in = 8'd20; div_code_in = 4'd3; load = 1'b1;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    en = 1'b0;
    chk(errs == 0, "R7 update at wrap mismatches", errs, 0);

    // R8: disable mid period forces low at once, re-enable restarts from count 0
    load_idle(10, 20, 3);
    en = 1'b1;
    repeat (50) @(negedge clk);
    en = 1'b0;
    #1;
    chk(pwm_out == 1'b0, "R8 low in the cycle en drops", int'(pwm_out), 0);
    repeat (3) @(negedge clk);
    shape(40, 84, 1, fresh_errs);
    chk(fresh_errs == 0, "R8 fresh period after re-enable", fresh_errs, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule